// File: doc/BRIEF.md
# Advanced Error Reporting Status and Header Logger

This block holds the error status side of an advanced error reporting capability. Each error source gives it a one-cycle pulse. Uncorrectable sources arrive on one vector and correctable sources on another. The transaction-layer packet header that goes with the error arrives in the same cycle. The block keeps the following state:

- a status bit for every source;
- a mask for every source;
- a fatal/non-fatal severity for every uncorrectable source;
- a pointer to the first unmasked uncorrectable error;
- a four-word copy of the header of that error.

From this state it raises fatal, non-fatal and correctable report pulses toward the host.

Configuration software reaches the state through a small register port. The port takes a byte address, a write strobe and write data, and it returns read data combinationally. All registers are sticky. Only the cold power-on reset `por_n` initializes them. The combined hot-reset/function-level-reset input `soft_rst` leaves them unchanged. It only holds the report pulses low.

Top module: `aer_err_logger`

## Requirements
- R1: After the cold reset `por_n` is low, every register reads 0. This covers uncorrectable status (+04h), uncorrectable mask (+08h), correctable status (+10h), correctable mask (+14h), the control register (+18h) and the header words. Severity (+0Ch) reads the parameter `UE_SEV_INIT`, which defaults to 0. None of the report outputs is high.
- R2: While `soft_rst` is high, no register changes value unless an error pulse or a register write acts on it.
- R3: In a cycle where `soft_rst` is high, no report pulse is emitted for the errors of that cycle.
- R4: An error pulse sets its status bit whether or not the bit is masked. Status is at +04h for uncorrectable sources and +10h for correctable sources. Writing 1 to a status bit clears it. A set and a clear of the same bit in the same cycle leaves the bit set.
- R5: The mask registers (+08h, +14h) and the severity register (+0Ch) are read/write. Bits above the number of sources read 0. A write takes effect on the cycle after the write.
- R6: An unmasked uncorrectable error pulse in cycle t produces a one-cycle pulse in cycle t+1. The pulse is on `fatal_o` if the error's severity bit is 1 and on `nonfatal_o` if it is 0.
- R7: A masked uncorrectable error produces no report pulse. It leaves the first-error pointer and the header log unchanged.
- R8: An unmasked correctable error pulse in cycle t produces a one-cycle pulse on `cor_o` in cycle t+1. A masked correctable error produces none.
- R9: The first-error pointer reads in bits [4:0] of the control register at +18h. It takes the lowest bit index among the unmasked uncorrectable errors of a cycle. It stays fixed while the status bit it points to remains set.
- R10: The header log takes `hdr_i` in the same cycle that the first-error pointer is loaded, and at no other time. Word i (bits 32i+31:32i) reads at +1Ch + 4i.
- R11: Offsets outside the set above read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Cold power-on reset, active low, asynchronous |
| soft_rst | input | 1 | Hot reset or function-level reset; sticky state ignores it |
| ue_err_i | input | NUM_UE | Uncorrectable error pulses, one per source |
| ce_err_i | input | NUM_CE | Correctable error pulses, one per source |
| hdr_i | input | 32*HDR_WORDS | Header of the packet tied to this cycle's errors |
| cfg_addr | input | 8 | Register byte offset from the capability base |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr`, combinational |
| fatal_o | output | 1 | Fatal uncorrectable report pulse |
| nonfatal_o | output | 1 | Non-fatal uncorrectable report pulse |
| cor_o | output | 1 | Correctable report pulse |

## Verification
An error or a write applied in cycle t lands at the clock edge that closes that cycle. The report pulses and the register contents it produces are therefore due in cycle t+1, and the pulse is gone in cycle t+2. The bench drives each stimulus for exactly one cycle on the falling edge and removes it two nanoseconds after the next rising edge. It samples the pulse outputs at that same point, which is inside cycle t+1. Register reads are combinational, so they are sampled one nanosecond after the address changes, in a cycle with no stimulus applied. A reference model is updated once per edge in the same order and supplies every expected value.

// File: rtl/aer_err_logger.sv
module aer_err_logger #(
  parameter int NUM_UE = 26,
  parameter int NUM_CE = 16,
  parameter int HDR_WORDS = 4,
  parameter logic [NUM_UE-1:0] UE_SEV_INIT = '0
) (
  input  logic                   clk,
  input  logic                   por_n,
  input  logic                   soft_rst,
  input  logic [NUM_UE-1:0]      ue_err_i,
  input  logic [NUM_CE-1:0]      ce_err_i,
  input  logic [32*HDR_WORDS-1:0] hdr_i,
  input  logic [7:0]             cfg_addr,
  input  logic                   cfg_we,
  input  logic [31:0]            cfg_wdata,
  output logic [31:0]            cfg_rdata,
  output logic                   fatal_o,
  output logic                   nonfatal_o,
  output logic                   cor_o
);
  localparam int FEP_W = 5;
  localparam int HDR_BASE = 7;

  logic [NUM_UE-1:0] ue_st, ue_mask, ue_sev, ue_clr, ue_kept, ue_new;
  logic [NUM_CE-1:0] ce_st, ce_mask, ce_clr;
  logic [FEP_W-1:0] fep, fep_low;
  logic fep_vld, lock, cap;
  logic [HDR_WORDS-1:0][31:0] hdr_q;
  logic [5:0] widx;
  logic unused_ok;

  assign widx = cfg_addr[7:2];
  assign unused_ok = ^{cfg_addr[1:0], cfg_wdata};

  assign ue_clr  = (cfg_we && widx == 6'd1) ? cfg_wdata[NUM_UE-1:0] : '0;
  assign ce_clr  = (cfg_we && widx == 6'd4) ? cfg_wdata[NUM_CE-1:0] : '0;
  assign ue_kept = ue_st & ~ue_clr;
  assign ue_new  = ue_err_i & ~ue_mask;
  assign lock    = fep_vld && ue_kept[fep];
  assign cap     = !lock && (|ue_new);

  always_comb begin
    fep_low = '0;
    for (int i = NUM_UE - 1; i >= 0; i--)
      if (ue_new[i]) fep_low = FEP_W'(i);
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      ue_st      <= '0;
      ue_mask    <= '0;
      ue_sev     <= UE_SEV_INIT;
      ce_st      <= '0;
      ce_mask    <= '0;
      fep        <= '0;
      fep_vld    <= 1'b0;
      hdr_q      <= '0;
      fatal_o    <= 1'b0;
      nonfatal_o <= 1'b0;
      cor_o      <= 1'b0;
    end else begin
      ue_st <= ue_kept | ue_err_i;
      ce_st <= (ce_st & ~ce_clr) | ce_err_i;
      if (cfg_we && widx == 6'd2) ue_mask <= cfg_wdata[NUM_UE-1:0];
      if (cfg_we && widx == 6'd3) ue_sev  <= cfg_wdata[NUM_UE-1:0];
      if (cfg_we && widx == 6'd5) ce_mask <= cfg_wdata[NUM_CE-1:0];
      fep_vld <= lock | cap;
      if (cap) begin
        fep   <= fep_low;
        hdr_q <= hdr_i;
      end
      fatal_o    <= (|(ue_new & ue_sev)) & ~soft_rst;
      nonfatal_o <= (|(ue_new & ~ue_sev)) & ~soft_rst;
      cor_o      <= (|(ce_err_i & ~ce_mask)) & ~soft_rst;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (widx)
      6'd1: cfg_rdata = 32'(ue_st);
      6'd2: cfg_rdata = 32'(ue_mask);
      6'd3: cfg_rdata = 32'(ue_sev);
      6'd4: cfg_rdata = 32'(ce_st);
      6'd5: cfg_rdata = 32'(ce_mask);
      6'd6: cfg_rdata = 32'(fep);
      default: begin
        for (int i = 0; i < HDR_WORDS; i++)
          if (widx == 6'(HDR_BASE + i)) cfg_rdata = hdr_q[i];
      end
    endcase
  end

  a_r4_status_sets: assert property (@(posedge clk) disable iff (!por_n)
    1'b1 |=> ((ue_st & $past(ue_err_i)) == $past(ue_err_i)) &&
             ((ce_st & $past(ce_err_i)) == $past(ce_err_i)));
  a_r6_fatal_cause: assert property (@(posedge clk) disable iff (!por_n)
    fatal_o |-> $past(|(ue_err_i & ~ue_mask & ue_sev)));
  a_r6_nonfatal_cause: assert property (@(posedge clk) disable iff (!por_n)
    nonfatal_o |-> $past(|(ue_err_i & ~ue_mask & ~ue_sev)));
  a_r8_cor_cause: assert property (@(posedge clk) disable iff (!por_n)
    cor_o |-> $past(|(ce_err_i & ~ce_mask)));
  a_r7_masked_quiet: assert property (@(posedge clk) disable iff (!por_n)
    ((ue_err_i & ~ue_mask) == '0) |=> $stable(fep) && $stable(hdr_q));
  a_r9_fep_locked: assert property (@(posedge clk) disable iff (!por_n)
    (fep_vld && ue_st[fep] && !(cfg_we && widx == 6'd1)) |=> $stable(fep));
  a_r3_soft_quiet: assert property (@(posedge clk) disable iff (!por_n)
    soft_rst |=> !fatal_o && !nonfatal_o && !cor_o);
  a_r2_soft_sticky: assert property (@(posedge clk) disable iff (!por_n)
    (soft_rst && !cfg_we && ue_err_i == '0 && ce_err_i == '0) |=>
      $stable(ue_st) && $stable(ce_st) && $stable(ue_mask) && $stable(ue_sev) &&
      $stable(ce_mask) && $stable(fep) && $stable(hdr_q));
endmodule

// File: tb/sim_aer_err_logger.sv
`timescale 1ns/1ps
module sim_aer_err_logger;
  localparam int NUE = 26, NCE = 16;
  logic clk = 0, por_n = 0, soft_rst = 0, cfg_we = 0;
  logic [NUE-1:0] ue_err_i = '0;
  logic [NCE-1:0] ce_err_i = '0;
  logic [127:0] hdr_i = '0;
  logic [7:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic fatal_o, nonfatal_o, cor_o;
  int total = 0, fails = 0;

  logic [NUE-1:0] m_ust, m_umsk, m_usev;
  logic [NCE-1:0] m_cst, m_cmsk;
  logic [4:0] m_fep;
  logic m_fvld;
  logic [127:0] m_hdr;

  aer_err_logger u0 (.clk(clk), .por_n(por_n), .soft_rst(soft_rst), .ue_err_i(ue_err_i),
    .ce_err_i(ce_err_i), .hdr_i(hdr_i), .cfg_addr(cfg_addr), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .fatal_o(fatal_o),
    .nonfatal_o(nonfatal_o), .cor_o(cor_o));

  always #4 clk = ~clk;

  initial begin
    #2000000;
    total++; fails++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] lowest(logic [NUE-1:0] v);
    for (int i = 0; i < NUE; i++) if (v[i]) return 5'(i);
    return 5'd0;
  endfunction

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    cfg_addr = a; cfg_we = 0;
    #1 chk(tag, cfg_rdata, exp);
  endtask

  task automatic rd_all(string tag);
    rd(8'h04, 32'(m_ust), {tag, " R4 ustat"});
    rd(8'h08, 32'(m_umsk), {tag, " R5 umask"});
    rd(8'h0C, 32'(m_usev), {tag, " R5 usev"});
    rd(8'h10, 32'(m_cst), {tag, " R4 cstat"});
    rd(8'h14, 32'(m_cmsk), {tag, " R5 cmask"});
    rd(8'h18, 32'(m_fep), {tag, " R9 fep"});
    for (int i = 0; i < 4; i++) rd(8'h1C + 8'(4 * i), m_hdr[32*i +: 32], {tag, " R10 hdr"});
  endtask

  task automatic step(logic [NUE-1:0] ue, logic [NCE-1:0] ce, logic [127:0] h,
                      logic we, logic [7:0] a, logic [31:0] wd, logic sr);
    logic ef, en, ec, lk;
    logic [NUE-1:0] uclr, unew;
    logic [NCE-1:0] cclr;
    @(negedge clk);
    ue_err_i = ue; ce_err_i = ce; hdr_i = h; cfg_we = we; cfg_addr = a;
    cfg_wdata = wd; soft_rst = sr;
    unew = ue & ~m_umsk;
    ef = (|(unew & m_usev)) && !sr;
    en = (|(unew & ~m_usev)) && !sr;
    ec = (|(ce & ~m_cmsk)) && !sr;
    uclr = (we && a[7:2] == 6'd1) ? wd[NUE-1:0] : '0;
    cclr = (we && a[7:2] == 6'd4) ? wd[NCE-1:0] : '0;
    lk = m_fvld && ((m_ust & ~uclr) >> m_fep) & 1'b1;
    @(posedge clk);
    #2;
    chk(sr ? "R3 fatal" : "R6 fatal", 32'(fatal_o), 32'(ef));
    chk(sr ? "R3 nonfatal" : "R6 nonfatal", 32'(nonfatal_o), 32'(en));
    chk(sr ? "R3 cor" : "R8 cor", 32'(cor_o), 32'(ec));
    ue_err_i = '0; ce_err_i = '0; cfg_we = 0; soft_rst = 0;
    m_ust = (m_ust & ~uclr) | ue;
    m_cst = (m_cst & ~cclr) | ce;
    if (!lk && unew != '0) begin
      m_fep = lowest(unew); m_hdr = h; m_fvld = 1;
    end else m_fvld = lk;
    if (we && a[7:2] == 6'd2) m_umsk = wd[NUE-1:0];
    if (we && a[7:2] == 6'd3) m_usev = wd[NUE-1:0];
    if (we && a[7:2] == 6'd5) m_cmsk = wd[NCE-1:0];
  endtask

  function automatic logic [127:0] rhdr();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    logic [127:0] h;
    logic [7:0] a;
    int r;
    void'($urandom(32'h5eed));
    m_ust = '0; m_umsk = '0; m_usev = '0; m_cst = '0; m_cmsk = '0;
    m_fep = '0; m_fvld = 0; m_hdr = '0;
    repeat (3) @(negedge clk);
    por_n = 1;
    chk("R1 fatal reset", 32'(fatal_o), 0);
    chk("R1 nonfatal reset", 32'(nonfatal_o), 0);
    chk("R1 cor reset", 32'(cor_o), 0);
    rd_all("R1 reset");

    step('0, '0, '0, 1, 8'h0C, 32'h5, 0);
    step('0, '0, '0, 1, 8'h08, 32'hFFFF_FFFF, 0);
    rd(8'h08, 32'h03FF_FFFF, "R5 mask width");
    step('0, '0, '0, 1, 8'h08, 32'h0, 0);
    h = rhdr();
    step(26'h0A, '0, h, 0, 8'h0, 0, 0);
    rd(8'h18, 32'd1, "R9 lowest index");
    rd(8'h1C, h[31:0], "R10 hdr word0");
    rd(8'h28, h[127:96], "R10 hdr word3");
    step(26'h01, '0, rhdr(), 0, 8'h0, 0, 0);
    rd(8'h18, 32'd1, "R9 locked");
    rd(8'h20, h[63:32], "R10 hdr kept");
    step('0, '0, '0, 1, 8'h04, 32'hFFFF_FFFF, 0);
    step('0, '0, '0, 1, 8'h08, 32'h10, 0);
    step(26'h10, '0, rhdr(), 0, 8'h0, 0, 0);
    rd(8'h04, 32'h10, "R4 masked sets status");
    rd(8'h18, 32'd1, "R7 fep unchanged");
    rd(8'h24, h[95:64], "R7 hdr unchanged");
    step(26'h10, '0, '0, 1, 8'h04, 32'h10, 0);
    rd(8'h04, 32'h10, "R4 set wins over clear");
    step('0, 16'h4, '0, 0, 8'h0, 0, 0);
    step('0, '0, '0, 1, 8'h14, 32'h4, 0);
    step('0, 16'h4, '0, 0, 8'h0, 0, 0);
    rd(8'h10, 32'h4, "R8 status set");
    step(26'h20, 16'h1, rhdr(), 0, 8'h0, 0, 1);
    step('0, '0, rhdr(), 0, 8'h0, 0, 1);
    rd_all("R2 soft reset");
    step('0, '0, '0, 1, 8'h2C, 32'hFFFF_FFFF, 0);
    step('0, '0, '0, 1, 8'h00, 32'hFFFF_FFFF, 0);
    rd(8'h00, 0, "R11 offset 00");
    rd(8'h2C, 0, "R11 offset 2C");
    rd(8'h3C, 0, "R11 offset 3C");
    rd_all("R11 no side effect");

    for (int n = 0; n < 400; n++) begin
      r = $urandom % 8;
      a = 8'h04 + 8'(4 * ($urandom % 5));
      step(NUE'($urandom & $urandom & $urandom & $urandom),
           NCE'($urandom & $urandom & $urandom),
           rhdr(), r == 0, a, $urandom & $urandom, r == 1);
      if (n % 20 == 19) rd_all("random");
    end
    rd_all("final");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule